// File: doc/BRIEF.md
# Accelerometer Pulse Event Detector

This block watches a stream of three-axis acceleration samples (signed 8-bit, one per axis) and recognises three kinds of motion event: a single short pulse, a double pulse (two short pulses separated by a quiet gap), and freefall (every watched axis close to zero for a sustained period). All timing is measured in accepted samples, not in clock cycles. The resulting event strobes and per-axis source flags go to a downstream interrupt block.

Samples enter on a valid/ready stream. The detector never applies back-pressure: `smp_ready` is held high, so a sample is consumed on every cycle where `smp_valid` is high, and cycles without `smp_valid` do not advance any timer. The threshold, the three timing values, the axis mask and the mode select are plain static inputs. They are expected to change only together with a `det_clear` pulse. `det_clear` returns the sequencer to idle and clears the source flags.

Top module: `accel_pulse_detector`

## Requirements
- R1: Each axis is compared by magnitude. In motion mode (`and_mode`=0), an axis counts as an excursion when its absolute value is greater than or equal to `thresh`. The value -128 counts as magnitude 128.
- R2: An axis whose bit is set in `axis_off` is ignored. Bit 0 is X, bit 1 is Y and bit 2 is Z. Such an axis never starts or extends a pulse and never appears in `src_axes` after a pulse event.
- R3: A first pulse qualifies if the excursion lasts 1 to `dur_win`+1 consecutive samples and is followed by a sample with no excursion. `single_evt` pulses in the cycle after that quiet sample is accepted. At the same time, `src_axes` is loaded with the axes that exceeded the threshold during the pulse.
- R4: A pulse that is still above threshold on its (`dur_win`+2)-th sample is rejected. No event is raised, and the detector waits for a quiet sample before it returns to idle.
- R5: With `win2`=0, only single pulses are detected: after each single event the detector returns to idle and `double_evt` never fires.
- R6: After a qualified first pulse, the next `lat_time`+1 samples are ignored, whatever their values.
- R7: The second window then lasts `win2` samples. An excursion inside it starts a second pulse. If that pulse qualifies under the R3 duration rule, `double_evt` pulses and `src_axes` takes the second pulse's axes.
- R8: If the second window closes with no excursion, the detector returns to idle without any event. The next excursion is treated as a new first pulse.
- R9: In freefall mode (`and_mode`=1), every enabled axis must have a magnitude strictly below `thresh`. When that holds for `lat_time`+2 consecutive samples, `ff_evt` pulses once and `src_axes` is loaded with the enabled axes. No further event comes until a sample breaks the condition.
- R10: `src_axes` holds its value until the next event or `det_clear`. `det_clear` zeroes `src_axes` and abandons any sequence in progress.
- R11: `smp_ready` is always high, and timers advance only on accepted samples. Sample values presented while `smp_valid` is low have no effect.
- R12: Each event output is high for exactly one cycle, and at most one event output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready (always high) |
| acc_x | input | 8 | X sample, signed |
| acc_y | input | 8 | Y sample, signed |
| acc_z | input | 8 | Z sample, signed |
| axis_off | input | 3 | Per-axis exclude mask, bit 0 = X |
| and_mode | input | 1 | 0 = pulse (any axis), 1 = freefall (all axes) |
| thresh | input | 8 | Magnitude threshold |
| dur_win | input | 8 | Maximum pulse length minus one, in samples |
| lat_time | input | 8 | Quiet latency length minus one, in samples |
| win2 | input | 8 | Second-pulse window length in samples, 0 = single only |
| det_clear | input | 1 | Restart detection and clear source flags |
| single_evt | output | 1 | Single-pulse event strobe |
| double_evt | output | 1 | Double-pulse event strobe |
| ff_evt | output | 1 | Freefall event strobe |
| src_axes | output | 3 | Axes that produced the latest event |

## Verification
A sample-by-sample table covers several cases: a clean double tap; a pulse one sample too long; a second window that expires before a new tap; a threshold-equal negative sample; and a value one below threshold that must not open a second pulse. Comparing each row's strobes with the expected ones distinguishes off-by-one errors in the duration, latency and window counters. Directed runs cover the remaining cases. Masked axes show that exclusion takes effect. A single-only window shows that no double event fires. Freefall runs that are interrupted, and runs with one axis masked, show both the consecutive-sample rule and the choice of enabled axes. Held input values with no strobe show that timing follows accepted samples only.

// File: rtl/apd_pkg.sv
`timescale 1ns/1ps
package apd_pkg;
  localparam int unsigned APD_AXES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE1,
    ST_LATENCY,
    ST_WINDOW,
    ST_PULSE2,
    ST_REJECT,
    ST_FALL,
    ST_HOLD
  } apd_state_e;
endpackage

// File: rtl/apd_axis_cmp.sv
`timescale 1ns/1ps
module apd_axis_cmp #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [SAMPLE_W-1:0] thresh,
  input  logic                       enable,
  output logic                       over,
  output logic                       under
);
  localparam int unsigned MAG_W = SAMPLE_W + 1;

  logic [MAG_W-1:0] mag;

  // Widened so the most negative code maps to its true magnitude.
  always_comb begin
    if (sample[SAMPLE_W-1]) mag = {1'b0, ~sample} + MAG_W'(1);
    else                    mag = {1'b0, sample};
  end

  assign over  = enable && (mag >= {1'b0, thresh});
  assign under = !enable || (mag < {1'b0, thresh});
endmodule

// File: rtl/apd_seq.sv
`timescale 1ns/1ps
module apd_seq
  import apd_pkg::*;
#(
  parameter int unsigned N_AXES = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              det_clear,
  input  logic              and_mode,
  input  logic [N_AXES-1:0] over,
  input  logic              under_all,
  input  logic [N_AXES-1:0] en_mask,
  input  logic [CNT_W-1:0]  dur_win,
  input  logic [CNT_W-1:0]  lat_time,
  input  logic [CNT_W-1:0]  win2,
  output logic              single_evt,
  output logic              double_evt,
  output logic              ff_evt,
  output logic [N_AXES-1:0] src_axes
);
  apd_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [N_AXES-1:0] pulse_axes;
  logic              any_over;
  logic [CNT_W-1:0]  win_last;

  assign any_over = |over;
  assign win_last = win2 - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || det_clear) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      pulse_axes <= '0;
      src_axes   <= '0;
      single_evt <= 1'b0;
      double_evt <= 1'b0;
      ff_evt     <= 1'b0;
    end else begin
      single_evt <= 1'b0;
      double_evt <= 1'b0;
      ff_evt     <= 1'b0;
      if (fire) begin
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (and_mode) begin
              if (under_all) state <= ST_FALL;
            end else if (any_over) begin
              state      <= ST_PULSE1;
              pulse_axes <= over;
            end
          end
          ST_PULSE1, ST_PULSE2: begin
            if (any_over) begin
              pulse_axes <= pulse_axes | over;
              if (cnt == dur_win) state <= ST_REJECT;
              else                cnt   <= cnt + CNT_W'(1);
            end else begin
              src_axes <= pulse_axes;
              cnt      <= '0;
              if (state == ST_PULSE2) begin
                double_evt <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                single_evt <= 1'b1;
                state      <= (win2 == '0) ? ST_IDLE : ST_LATENCY;
              end
            end
          end
          ST_LATENCY: begin
            if (cnt == lat_time) begin
              state <= ST_WINDOW;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_WINDOW: begin
            if (any_over) begin
              state      <= ST_PULSE2;
              pulse_axes <= over;
              cnt        <= '0;
            end else if (cnt == win_last) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_REJECT: begin
            if (!any_over) state <= ST_IDLE;
          end
          ST_FALL: begin
            if (!under_all) begin
              state <= ST_IDLE;
            end else if (cnt == lat_time) begin
              ff_evt   <= 1'b1;
              src_axes <= en_mask;
              state    <= ST_HOLD;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_HOLD: begin
            if (!under_all) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_evt_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({single_evt, double_evt, ff_evt}) <= 1);

  p_single_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    single_evt |=> !single_evt);

  p_evt_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (single_evt || double_evt || ff_evt) |-> $past(fire));

  p_no_double_zero_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    double_evt |-> ($past(win2) != '0));

  p_double_motion_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    double_evt |-> !$past(and_mode));

  p_ff_freefall_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ff_evt |-> $past(and_mode));

  p_clear_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    det_clear |=> (src_axes == '0 && !single_evt && !double_evt && !ff_evt));

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_evt && !double_evt && !ff_evt && !$past(det_clear)) |-> $stable(src_axes));
endmodule

// File: rtl/accel_pulse_detector.sv
`timescale 1ns/1ps
module accel_pulse_detector
  import apd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] acc_x,
  input  logic [SAMPLE_W-1:0] acc_y,
  input  logic [SAMPLE_W-1:0] acc_z,
  input  logic [2:0]          axis_off,
  input  logic                and_mode,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic [CNT_W-1:0]    dur_win,
  input  logic [CNT_W-1:0]    lat_time,
  input  logic [CNT_W-1:0]    win2,
  input  logic                det_clear,
  output logic                single_evt,
  output logic                double_evt,
  output logic                ff_evt,
  output logic [2:0]          src_axes
);
  localparam int unsigned N_AXES = APD_AXES;

  logic signed [SAMPLE_W-1:0] axis_smp [N_AXES];
  logic [N_AXES-1:0]          en_mask;
  logic [N_AXES-1:0]          over;
  logic [N_AXES-1:0]          under;
  logic                       fire;

  assign axis_smp[0] = acc_x;
  assign axis_smp[1] = acc_y;
  assign axis_smp[2] = acc_z;
  assign en_mask     = ~axis_off;
  assign smp_ready   = 1'b1;
  assign fire        = smp_valid && smp_ready;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    apd_axis_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .sample (axis_smp[a]),
      .thresh (thresh),
      .enable (en_mask[a]),
      .over   (over[a]),
      .under  (under[a])
    );
  end

  apd_seq #(.N_AXES(N_AXES), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .det_clear  (det_clear),
    .and_mode   (and_mode),
    .over       (over),
    .under_all  (&under),
    .en_mask    (en_mask),
    .dur_win    (dur_win),
    .lat_time   (lat_time),
    .win2       (win2),
    .single_evt (single_evt),
    .double_evt (double_evt),
    .ff_evt     (ff_evt),
    .src_axes   (src_axes)
  );

  p_masked_axis_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (single_evt || double_evt) |-> ((src_axes & $past(axis_off)) == 3'b000));

  p_ready_no_evt_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(single_evt) |-> $past(smp_valid));
endmodule

// File: tb/accel_pulse_detector_bench.sv
`timescale 1ns/1ps
module accel_pulse_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] acc_x = '0, acc_y = '0, acc_z = '0;
  logic [2:0] axis_off = '0;
  logic       and_mode = 1'b0;
  logic [7:0] thresh = 8'd50, dur_win = 8'd2, lat_time = 8'd1, win2 = 8'd3;
  logic       det_clear = 1'b0;
  logic       single_evt, double_evt, ff_evt;
  logic [2:0] src_axes;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  accel_pulse_detector u_accel_pulse_detector (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z), .axis_off(axis_off),
    .and_mode(and_mode), .thresh(thresh), .dur_win(dur_win),
    .lat_time(lat_time), .win2(win2), .det_clear(det_clear),
    .single_evt(single_evt), .double_evt(double_evt), .ff_evt(ff_evt),
    .src_axes(src_axes)
  );

  // x, y, z, single, double, src ; thresh 50, dur 2, latency 1, window 3
  localparam int NV = 28;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b000},
    {8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, 3'b000},
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'b001},
    {8'h64, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'hBA, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'hBA, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'b010},
    {8'h00, 8'h00, 8'h37, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h37, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h37, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h37, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b010},
    {8'hCE, 8'h00, 8'h00, 1'b0, 1'b0, 3'b010},
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'b001},
    {8'h31, 8'h31, 8'hCF, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h31, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 3'b001},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'b001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic s, input logic d,
                         input logic f, input logic [2:0] src);
    chk({tag, " single"}, 32'(single_evt), 32'(s));
    chk({tag, " double"}, 32'(double_evt), 32'(d));
    chk({tag, " freefall"}, 32'(ff_evt), 32'(f));
    chk({tag, " src"}, 32'(src_axes), 32'(src));
  endtask

  // Drives one accepted sample; returns at the negedge after its edge.
  task automatic send(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
    @(negedge clk);
    acc_x = x; acc_y = y; acc_z = z; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_det();
    @(negedge clk);
    det_clear = 1'b1;
    @(negedge clk);
    det_clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R12 reset", 1'b0, 1'b0, 1'b0, 3'b000);
    chk("R11 ready", 32'(smp_ready), 32'd1);

    // Table: R1 threshold, R3 single, R4 too long, R6 latency, R7 double, R8 timeout
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][28:21], VEC[i][20:13], VEC[i][12:5]);
      chk_out($sformatf("R1 R3 R4 R6 R7 R8 row%0d", i), VEC[i][4], VEC[i][3], 1'b0, VEC[i][2:0]);
    end

    clear_det();
    chk("R10 clear src", 32'(src_axes), 32'd0);

    // R2 masked axis
    axis_off = 3'b001;
    send(8'd100, 8'd0, 8'd0); chk_out("R2 masked start", 1'b0, 1'b0, 1'b0, 3'b000);
    send(8'd0, 8'd0, 8'd0);   chk_out("R2 masked quiet", 1'b0, 1'b0, 1'b0, 3'b000);
    send(8'd100, 8'd60, 8'd0); chk_out("R2 mixed start", 1'b0, 1'b0, 1'b0, 3'b000);
    send(8'd0, 8'd0, 8'd0);   chk_out("R2 mixed end", 1'b1, 1'b0, 1'b0, 3'b010);
    clear_det();
    axis_off = 3'b000;

    // R10 clear mid-pulse
    send(8'd60, 8'd0, 8'd0);
    clear_det();
    send(8'd0, 8'd0, 8'd0);   chk_out("R10 abandoned", 1'b0, 1'b0, 1'b0, 3'b000);

    // R11 values without strobe
    @(negedge clk);
    acc_x = 8'd100;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11 no strobe", 32'(single_evt), 32'd0);
    end
    send(8'd0, 8'd0, 8'd0);   chk_out("R11 after idle", 1'b0, 1'b0, 1'b0, 3'b000);

    // R5 single-only
    clear_det();
    win2 = 8'd0;
    send(8'd60, 8'd0, 8'd0);  send(8'd0, 8'd0, 8'd0);
    chk_out("R5 first", 1'b1, 1'b0, 1'b0, 3'b001);
    send(8'd0, 8'd0, 8'd60);  chk_out("R5 restart", 1'b0, 1'b0, 1'b0, 3'b001);
    send(8'd0, 8'd0, 8'd0);   chk_out("R5 second single", 1'b1, 1'b0, 1'b0, 3'b100);
    clear_det();
    win2 = 8'd3;

    // R9 freefall, latency 2 -> event on 4th quiet sample
    and_mode = 1'b1; lat_time = 8'd2;
    clear_det();
    for (int k = 0; k < 3; k++) begin
      send(8'd10, 8'hF6, 8'd10); chk_out("R9 building", 1'b0, 1'b0, 1'b0, 3'b000);
    end
    send(8'd10, 8'd10, 8'd10); chk_out("R9 fire", 1'b0, 1'b0, 1'b1, 3'b111);
    send(8'd0, 8'd0, 8'd0);    chk_out("R9 hold", 1'b0, 1'b0, 1'b0, 3'b111);
    send(8'd0, 8'd0, 8'hC4);   chk_out("R9 break", 1'b0, 1'b0, 1'b0, 3'b111);
    for (int k = 0; k < 3; k++) begin
      send(8'd0, 8'd0, 8'd0);  chk_out("R9 rebuild", 1'b0, 1'b0, 1'b0, 3'b111);
    end
    send(8'd50, 8'd0, 8'd0);   chk_out("R9 equal breaks", 1'b0, 1'b0, 1'b0, 3'b111);
    clear_det();
    axis_off = 3'b100;
    for (int k = 0; k < 3; k++) begin
      send(8'd0, 8'd0, 8'd120); chk_out("R9 masked z", 1'b0, 1'b0, 1'b0, 3'b000);
    end
    send(8'd0, 8'd0, 8'd120);  chk_out("R9 masked fire", 1'b0, 1'b0, 1'b1, 3'b011);
    @(negedge clk);
    chk("R12 one cycle", 32'(ff_evt), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule